// File: doc/BRIEF.md
# Zone Recommended-Action Aging Timer

This block keeps a two-phase aging timeline for each zone of a small zone array. A zone is scheduled for either a reset-recommended or a finish-recommended timeline. First a delay phase runs: once enough time has passed, the matching attribute bit is set and a zone notice is raised. Then a limit phase runs: once the attribute has stood long enough, the block clears it, raises another notice and pulses an internal reset or finish action for that zone. The controller can also finish a zone on its own. That marks the zone as finished-by-controller, drops any timeline the zone had and raises a notice.

Time comes from a free-running 32-bit microsecond counter. All age comparisons use modulo-2^32 subtraction, so the counter may wrap. Zones are not checked every cycle. A scan pass starts once a scan period has passed since the previous pass started. The pass then visits one zone per clock, in ascending index order. A zone's timeline advances only while the zone is in a state that allows it.

Top module: `zone_aging_timer`

## Requirements
- R1: After reset, every attribute, the finished-by-controller flag, the notice-pending flag and every pulse output are 0.
- R2: A schedule request (`sched_finish` 1 = finish timeline, 0 = reset timeline) starts a delay phase and captures the current time. It is accepted only when the zone has no timeline in progress. A request for a zone that is already running is ignored.
- R3: When a scan visits a zone in its delay phase and the time since capture is at least the delay input, the attribute is set and the time is recaptured. A notice pulse is raised in the same cycle.
- R4: When a scan visits a zone whose attribute is set and the time since it was set is at least the limit input, the block clears the attribute and ends the timeline. It raises a one-cycle reset or finish action pulse for that zone and a notice.
- R5: Zone state encoding: 0 empty, 1 implicitly open, 2 explicitly open, 3 closed, 4 full, 5 to 7 no timeline. A finish timeline advances only in states 1, 2 and 3 with a nonzero finish limit. A reset timeline advances only in state 4 with a nonzero reset limit. Otherwise the timeline stays frozen.
- R6: Notice pulses and the setting of notice-pending happen only while `evt_en` is 1. On expiry, notice-pending is first cleared. It is then set again by the expiry notice, but only if the attribute was set.
- R7: A controller finish sets the sticky finished-by-controller flag, clears both attributes and any timeline, and raises a notice. It has priority over a scan or schedule for that zone in the same cycle.
- R8: A scan pass starts only when `now_us` minus the start time of the previous pass is at least `SCAN_US`. The first pass is measured from time 0. A pass visits one zone per cycle.
- R9: All elapsed-time comparisons are correct across a wrap of the 32-bit microsecond counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_us | input | TS_W | Free-running microsecond time |
| zone_state | input | 3*NUM_ZONES | Per-zone state code, zone z in bits [3z+2:3z] |
| sched_valid | input | 1 | Schedule request strobe |
| sched_finish | input | 1 | 1 = finish timeline, 0 = reset timeline |
| sched_zone | input | ZI_W | Zone index of the schedule request |
| afin_valid | input | 1 | Controller finish strobe |
| afin_zone | input | ZI_W | Zone index of the controller finish |
| evt_en | input | 1 | Zone notice enable |
| rst_delay_us | input | TS_W | Delay before reset is recommended |
| rst_limit_us | input | TS_W | Time the reset attribute stands; 0 disables |
| fin_delay_us | input | TS_W | Delay before finish is recommended |
| fin_limit_us | input | TS_W | Time the finish attribute stands; 0 disables |
| rst_rec | output | NUM_ZONES | Reset-recommended attribute per zone |
| fin_rec | output | NUM_ZONES | Finish-recommended attribute per zone |
| fin_by_ctrl | output | NUM_ZONES | Finished-by-controller flag per zone |
| notice_pend | output | NUM_ZONES | Notice-pending flag per zone |
| notice_pulse | output | NUM_ZONES | One-cycle notice per zone |
| reset_act | output | NUM_ZONES | One-cycle internal reset action per zone |
| finish_act | output | NUM_ZONES | One-cycle internal finish action per zone |

## Verification
The assertions assume that the strobe inputs are at a defined 0 while reset is asserted. They also assume that a zone's state code and the delay and limit inputs do not change in the cycle a timeline advances. The stimulus drives every input on the falling edge and holds the parameters constant through each scan pass. It moves `now_us` forward only in jumps, so the gap to the previous pass start is always known, including the jump across the counter wrap.

// File: rtl/zat_pkg.sv
package zat_pkg;

  typedef enum logic [2:0] {
    ZS_EMPTY  = 3'd0,
    ZS_IOPEN  = 3'd1,
    ZS_EOPEN  = 3'd2,
    ZS_CLOSED = 3'd3,
    ZS_FULL   = 3'd4,
    ZS_RONLY  = 3'd5,
    ZS_OFFL   = 3'd6,
    ZS_RSVD   = 3'd7
  } zstate_e;

  typedef struct packed {
    logic run_rst;
    logic run_fin;
    logic in_delay;
    logic rst_rec;
    logic fin_rec;
    logic by_ctrl;
    logic npend;
  } zflags_t;

  function automatic logic fin_state_ok(zstate_e st);
    return (st == ZS_IOPEN) || (st == ZS_EOPEN) || (st == ZS_CLOSED);
  endfunction

endpackage

// File: rtl/zat_scan_ctrl.sv
module zat_scan_ctrl #(
  parameter int NUM_ZONES = 4,
  parameter int TS_W      = 32,
  parameter int SCAN_US   = 10000,
  localparam int ZI_W     = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TS_W-1:0]      now_i,
  output logic [NUM_ZONES-1:0] visit_o
);

  localparam logic [TS_W-1:0] GAP  = TS_W'(SCAN_US);
  localparam logic [ZI_W-1:0] LAST = ZI_W'(NUM_ZONES - 1);

  logic            active_q, active_d;
  logic [ZI_W-1:0] idx_q, idx_d;
  logic [TS_W-1:0] mark_q, mark_d;
  logic [TS_W-1:0] gap_now;
  logic            start;

  assign gap_now = now_i - mark_q;
  assign start   = !active_q && (gap_now >= GAP);

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    mark_d   = mark_q;
    if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
      mark_d   = now_i;
    end else if (active_q) begin
      if (idx_q == LAST) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      mark_q   <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      if (start) mark_q <= mark_d;
    end
  end

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_visit
    assign visit_o[z] = active_q && (idx_q == ZI_W'(z));
  end

  // R8: the pass index never leaves the zone array
  a_r8_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (idx_q <= LAST));

  // R8: a new pass records the time at which it began
  a_r8_mark_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> (mark_q == $past(now_i)));

  // R8: at most one zone is visited per cycle
  a_r8_one_visit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(visit_o));

endmodule

// File: rtl/zat_zone_slot.sv
module zat_zone_slot
  import zat_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now_i,
  input  logic [2:0]      state_i,
  input  logic            evt_en_i,
  input  logic            visit_i,
  input  logic            sched_i,
  input  logic            sched_fin_i,
  input  logic            afin_i,
  input  logic [TS_W-1:0] rst_delay_i,
  input  logic [TS_W-1:0] rst_limit_i,
  input  logic [TS_W-1:0] fin_delay_i,
  input  logic [TS_W-1:0] fin_limit_i,
  output logic            rst_rec_o,
  output logic            fin_rec_o,
  output logic            by_ctrl_o,
  output logic            npend_o,
  output logic            notice_o,
  output logic            reset_act_o,
  output logic            finish_act_o
);

  zflags_t         fl_q, fl_d;
  logic [TS_W-1:0] ts_q, ts_d;
  logic            ts_en;
  logic            ntc_q, ntc_d;
  logic            ract_q, ract_d;
  logic            fact_q, fact_d;

  zstate_e         st;
  logic            fin_ok, rst_ok;
  logic            go_fin, go_rst, go_any;
  logic [TS_W-1:0] age, phase_lim;
  logic            due, attr_was, idle;

  assign st        = zstate_e'(state_i);
  assign fin_ok    = fin_state_ok(st) && (|fin_limit_i);
  assign rst_ok    = (st == ZS_FULL) && (|rst_limit_i);
  assign go_fin    = visit_i && fl_q.run_fin && fin_ok;
  assign go_rst    = visit_i && fl_q.run_rst && rst_ok;
  assign go_any    = go_fin || go_rst;
  assign age       = now_i - ts_q;
  assign phase_lim = go_fin ? (fl_q.in_delay ? fin_delay_i : fin_limit_i)
                            : (fl_q.in_delay ? rst_delay_i : rst_limit_i);
  assign due       = go_any && (age >= phase_lim);
  assign attr_was  = go_fin ? fl_q.fin_rec : fl_q.rst_rec;
  assign idle      = !fl_q.run_rst && !fl_q.run_fin;

  always_comb begin
    fl_d   = fl_q;
    ts_d   = ts_q;
    ts_en  = 1'b0;
    ntc_d  = 1'b0;
    ract_d = 1'b0;
    fact_d = 1'b0;
    if (afin_i) begin
      fl_d.run_rst  = 1'b0;
      fl_d.run_fin  = 1'b0;
      fl_d.in_delay = 1'b0;
      fl_d.rst_rec  = 1'b0;
      fl_d.fin_rec  = 1'b0;
      fl_d.by_ctrl  = 1'b1;
      if (evt_en_i) fl_d.npend = 1'b1;
      ntc_d = evt_en_i;
      ts_d  = '0;
      ts_en = 1'b1;
    end else if (due && fl_q.in_delay) begin
      if (go_fin) fl_d.fin_rec = 1'b1;
      else        fl_d.rst_rec = 1'b1;
      fl_d.in_delay = 1'b0;
      if (evt_en_i) fl_d.npend = 1'b1;
      ntc_d = evt_en_i;
      ts_d  = now_i;
      ts_en = 1'b1;
    end else if (due) begin
      if (go_fin) fl_d.fin_rec = 1'b0;
      else        fl_d.rst_rec = 1'b0;
      fl_d.run_rst  = 1'b0;
      fl_d.run_fin  = 1'b0;
      fl_d.in_delay = 1'b0;
      fl_d.npend    = 1'b0;
      if (attr_was) begin
        fl_d.npend = evt_en_i;
        ntc_d      = evt_en_i;
      end
      ract_d = go_rst;
      fact_d = go_fin;
      ts_d   = '0;
      ts_en  = 1'b1;
    end else if (sched_i && idle) begin
      fl_d.run_fin  = sched_fin_i;
      fl_d.run_rst  = !sched_fin_i;
      fl_d.in_delay = 1'b1;
      ts_d  = now_i;
      ts_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q   <= '0;
      ts_q   <= '0;
      ntc_q  <= 1'b0;
      ract_q <= 1'b0;
      fact_q <= 1'b0;
    end else begin
      fl_q   <= fl_d;
      if (ts_en) ts_q <= ts_d;
      ntc_q  <= ntc_d;
      ract_q <= ract_d;
      fact_q <= fact_d;
    end
  end

  assign rst_rec_o    = fl_q.rst_rec;
  assign fin_rec_o    = fl_q.fin_rec;
  assign by_ctrl_o    = fl_q.by_ctrl;
  assign npend_o      = fl_q.npend;
  assign notice_o     = ntc_q;
  assign reset_act_o  = ract_q;
  assign finish_act_o = fact_q;

  // R2: a zone never runs both timelines at once
  a_r2_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_q.run_rst && fl_q.run_fin));

  // R3: a rising attribute comes with a notice when notices are enabled
  a_r3_raise_notice: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_q.rst_rec) || $rose(fl_q.fin_rec)) |-> (ntc_q == $past(evt_en_i)));

  // R4: an action pulse leaves its attribute cleared
  a_r4_act_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ract_q |-> !fl_q.rst_rec) and (fact_q |-> !fl_q.fin_rec));

  // R6: notice-pending only rises while notices are enabled
  a_r6_np_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_q.npend) |-> $past(evt_en_i));

  // R7: a controller finish leaves the zone marked and without attributes
  a_r7_afin_done: assert property (@(posedge clk) disable iff (!rst_n)
    $past(afin_i) |-> (fl_q.by_ctrl && !fl_q.rst_rec && !fl_q.fin_rec));

endmodule

// File: rtl/zone_aging_timer.sv
module zone_aging_timer #(
  parameter int NUM_ZONES = 4,
  parameter int TS_W      = 32,
  parameter int SCAN_US   = 10000,
  localparam int ZI_W     = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1,
  localparam int ST_W     = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [TS_W-1:0]           now_us,
  input  logic [NUM_ZONES*ST_W-1:0] zone_state,
  input  logic                      sched_valid,
  input  logic                      sched_finish,
  input  logic [ZI_W-1:0]           sched_zone,
  input  logic                      afin_valid,
  input  logic [ZI_W-1:0]           afin_zone,
  input  logic                      evt_en,
  input  logic [TS_W-1:0]           rst_delay_us,
  input  logic [TS_W-1:0]           rst_limit_us,
  input  logic [TS_W-1:0]           fin_delay_us,
  input  logic [TS_W-1:0]           fin_limit_us,
  output logic [NUM_ZONES-1:0]      rst_rec,
  output logic [NUM_ZONES-1:0]      fin_rec,
  output logic [NUM_ZONES-1:0]      fin_by_ctrl,
  output logic [NUM_ZONES-1:0]      notice_pend,
  output logic [NUM_ZONES-1:0]      notice_pulse,
  output logic [NUM_ZONES-1:0]      reset_act,
  output logic [NUM_ZONES-1:0]      finish_act
);

  logic [NUM_ZONES-1:0] visit;

  zat_scan_ctrl #(
    .NUM_ZONES (NUM_ZONES),
    .TS_W      (TS_W),
    .SCAN_US   (SCAN_US)
  ) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .now_i   (now_us),
    .visit_o (visit)
  );

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    logic sel_sched, sel_afin;
    assign sel_sched = sched_valid && (sched_zone == ZI_W'(z));
    assign sel_afin  = afin_valid && (afin_zone == ZI_W'(z));

    zat_zone_slot #(
      .TS_W (TS_W)
    ) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .now_i        (now_us),
      .state_i      (zone_state[z*ST_W +: ST_W]),
      .evt_en_i     (evt_en),
      .visit_i      (visit[z]),
      .sched_i      (sel_sched),
      .sched_fin_i  (sched_finish),
      .afin_i       (sel_afin),
      .rst_delay_i  (rst_delay_us),
      .rst_limit_i  (rst_limit_us),
      .fin_delay_i  (fin_delay_us),
      .fin_limit_i  (fin_limit_us),
      .rst_rec_o    (rst_rec[z]),
      .fin_rec_o    (fin_rec[z]),
      .by_ctrl_o    (fin_by_ctrl[z]),
      .npend_o      (notice_pend[z]),
      .notice_o     (notice_pulse[z]),
      .reset_act_o  (reset_act[z]),
      .finish_act_o (finish_act[z])
    );
  end

  // R4: scanning one zone per cycle yields at most one internal action per cycle
  a_r4_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reset_act | finish_act));

endmodule

// File: tb/zone_aging_timer_test.sv
module zone_aging_timer_test;

  localparam int CLK_NS = 10;
  localparam int NZ     = 4;
  localparam int NROWS  = 17;
  localparam int SETTLE = 12;

  logic          clk;
  logic          rst_n;
  logic [31:0]   now_us;
  logic [11:0]   zone_state;
  logic          sched_valid, sched_finish;
  logic [1:0]    sched_zone;
  logic          afin_valid;
  logic [1:0]    afin_zone;
  logic          evt_en;
  logic [31:0]   rst_delay_us, rst_limit_us, fin_delay_us, fin_limit_us;
  logic [NZ-1:0] rst_rec, fin_rec, fin_by_ctrl, notice_pend;
  logic [NZ-1:0] notice_pulse, reset_act, finish_act;
  logic [NZ-1:0] acc_ntc, acc_ract, acc_fact;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  zone_aging_timer #(.NUM_ZONES(NZ), .TS_W(32), .SCAN_US(10000)) uut (
    .clk(clk), .rst_n(rst_n), .now_us(now_us), .zone_state(zone_state),
    .sched_valid(sched_valid), .sched_finish(sched_finish), .sched_zone(sched_zone),
    .afin_valid(afin_valid), .afin_zone(afin_zone), .evt_en(evt_en),
    .rst_delay_us(rst_delay_us), .rst_limit_us(rst_limit_us),
    .fin_delay_us(fin_delay_us), .fin_limit_us(fin_limit_us),
    .rst_rec(rst_rec), .fin_rec(fin_rec), .fin_by_ctrl(fin_by_ctrl),
    .notice_pend(notice_pend), .notice_pulse(notice_pulse),
    .reset_act(reset_act), .finish_act(finish_act)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // Row: {op, zone, rr, fr, fbc, npend, notice, reset_act, finish_act}
  // op 0 = advance time 10000 us, 1 = schedule reset, 2 = schedule finish, 3 = controller finish
  // zones: z0 full, z1 closed, z2 implicitly open, z3 empty
  localparam logic [31:0] TBL [NROWS] = '{
    {2'd1, 2'd0, 28'h0000000},  // R2 schedule reset z0 at 0
    {2'd2, 2'd1, 28'h0000000},  // R2 schedule finish z1 at 0
    {2'd2, 2'd3, 28'h0000000},  // R2 z3 empty: accepted, never advances
    {2'd0, 2'd0, 28'h0000000},  // t=10000 nothing due
    {2'd0, 2'd0, 28'h1001100},  // R3 t=20000 z0 reset recommended
    {2'd0, 2'd0, 28'h1203200},  // R3 t=30000 z1 finish recommended
    {2'd2, 2'd0, 28'h1203000},  // R2 z0 busy: request ignored
    {2'd0, 2'd0, 28'h1203000},  // t=40000
    {2'd2, 2'd2, 28'h1203000},  // R2 schedule finish z2 at 40000
    {2'd0, 2'd0, 28'h1203000},  // t=50000
    {2'd0, 2'd0, 28'h1203000},  // t=60000
    {2'd0, 2'd0, 28'h0407712},  // R4 t=70000 z0/z1 expire, z2 raised
    {2'd3, 2'd2, 28'h0047400},  // R7 controller finishes z2
    {2'd0, 2'd0, 28'h0047000},  // R5 t=80000
    {2'd1, 2'd1, 28'h0047000},  // R5 reset timeline on closed zone z1
    {2'd0, 2'd0, 28'h0047000},  // R5 t=90000 frozen
    {2'd0, 2'd0, 28'h0047000}   // R5 t=100000 frozen
  };

  function automatic string row_req(int i);
    case (i)
      0, 1, 2, 6, 8: return "R2";
      11:            return "R4";
      12:            return "R7";
      13, 14, 15, 16: return "R5";
      default:       return "R3";
    endcase
  endfunction

  function automatic logic [27:0] snap();
    return {rst_rec, fin_rec, fin_by_ctrl, notice_pend, acc_ntc, acc_ract, acc_fact};
  endfunction

  task automatic check(string req, logic [27:0] got, logic [27:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic accumulate();
    acc_ntc  |= notice_pulse;
    acc_ract |= reset_act;
    acc_fact |= finish_act;
  endtask

  task automatic step(int op, int zone, logic [31:0] dt);
    acc_ntc = '0; acc_ract = '0; acc_fact = '0;
    @(negedge clk);
    case (op)
      0: now_us = now_us + dt;
      1: begin sched_valid = 1'b1; sched_finish = 1'b0; sched_zone = 2'(zone); end
      2: begin sched_valid = 1'b1; sched_finish = 1'b1; sched_zone = 2'(zone); end
      default: begin afin_valid = 1'b1; afin_zone = 2'(zone); end
    endcase
    @(negedge clk);
    sched_valid = 1'b0;
    afin_valid  = 1'b0;
    accumulate();
    for (int k = 0; k < SETTLE; k++) begin
      @(negedge clk);
      accumulate();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    now_us = '0;
    sched_valid = 1'b0; sched_finish = 1'b0; sched_zone = '0;
    afin_valid = 1'b0; afin_zone = '0;
    evt_en = 1'b1;
    rst_delay_us = 32'd20000; rst_limit_us = 32'd50000;
    fin_delay_us = 32'd30000; fin_limit_us = 32'd40000;
    zone_state = {3'd0, 3'd1, 3'd3, 3'd4};
    acc_ntc = '0; acc_ract = '0; acc_fact = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    accumulate();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=timeout exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    // R1 reset state
    check("R1", snap(), 28'h0);

    for (int i = 0; i < NROWS; i++) begin
      step(int'(TBL[i][31:30]), int'(TBL[i][29:28]), 32'd10000);
      check(row_req(i), snap(), TBL[i][27:0]);
    end

    // R1 reset clears the sticky controller-finish flag
    do_reset();
    check("R1", snap(), 28'h0);

    // R6 notices disabled: attribute rises silently
    do_reset();
    evt_en = 1'b0;
    step(1, 0, 0);
    step(0, 0, 32'd20000);
    check("R6", snap(), 28'h1000000);
    evt_en = 1'b1;
    step(0, 0, 32'd50000);
    check("R6", snap(), 28'h0001110);

    // R5 zero reset limit disables the reset timeline
    do_reset();
    rst_limit_us = '0;
    step(1, 0, 0);
    step(0, 0, 32'd30000);
    check("R5", snap(), 28'h0);

    // R8 a due zone waits for the scan period
    do_reset();
    fin_delay_us = 32'd5000;
    step(2, 1, 0);
    step(0, 0, 32'd9000);
    check("R8", snap(), 28'h0);
    step(0, 0, 32'd1000);
    check("R8", snap(), 28'h0202200);

    // R9 counter wrap
    do_reset();
    step(0, 0, 32'hFFFF_C000);
    check("R9", snap(), 28'h0);
    step(2, 1, 0);
    step(0, 0, 32'd20000);
    check("R9", snap(), 28'h0);
    step(0, 0, 32'd10000);
    check("R9", snap(), 28'h0202200);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule